// File: doc/BRIEF.md
# Conditional branch resolution unit

This unit resolves one relative branch instruction at a time. It accepts a 16-bit branch opcode word together with the address of that word, a snapshot of the N, Z, V and C condition flags and the current stack pointer. From the opcode it determines how many extension words carry the displacement, collects them, evaluates the branch condition and issues one result. The result holds the taken decision, the branch target and the fall-through address. For the call variant it also holds a push request, the value to push and the stack pointer after the push.

The 8-bit displacement field in the opcode selects the form. Most values are a short displacement. 0x00 is an escape that calls for one 16-bit extension word, and 0xFF is an escape that calls for a 32-bit displacement carried in two words. This means a branch to the very next instruction must use the 16-bit form. Extension words come in through a valid/ready port, one per cycle. The result stays presented until the consumer takes it, and no new opcode is accepted before then. The unit has no flag outputs, so branches leave the condition flags untouched.

Top module: `bru_top`

## Requirements
- R1: The opcode holds the condition in bits 11:8 and a two's-complement displacement d8 in bits 7:0. Bits 15:12 are not examined. When d8 is neither 0x00 nor 0xFF, the result appears in the cycle after the opcode is accepted, with target = address + 2 + sign-extended d8 and fall-through = address + 2.
- R2: When d8 = 0x00, exactly one extension word is taken and sign-extended as the displacement. The target is address + 2 + that value, and the fall-through is address + 4.
- R3: When d8 = 0xFF, two extension words are taken, most significant half first, forming a 32-bit displacement. The target is address + 2 + that value, and the fall-through is address + 6.
- R4: The taken decision for conditions 0010 to 1111 follows this table. 0010: !C & !Z. 0011: C | Z. 0100: !C. 0101: C. 0110: !Z. 0111: Z. 1000: !V. 1001: V. 1010: !N. 1011: N. 1100: N == V. 1101: N != V. 1110: Z clear and N == V. 1111: Z set or N != V.
- R5: Condition 0000 is always taken and raises no push request.
- R6: Condition 0001 is a call. It is always taken and raises the push request. The push value is the fall-through address, and the new stack pointer is the input stack pointer minus ADDR_W/8.
- R7: ext_ready is low while the unit is idle or while a result is pending, so extension words offered then are not consumed. A result is issued only after all of its extension words have arrived.
- R8: op_ready is low from opcode acceptance until the result is consumed (res_valid and res_ready high together). While res_ready stays low, the result stays valid and unchanged.
- R9: The flags and stack pointer are sampled when the opcode is accepted. Later changes to them do not alter the pending result.
- R10: For every condition other than 0001, the push request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode offered |
| op_ready | output | 1 | Unit idle, opcode will be taken |
| op_word | input | 16 | Branch opcode word |
| op_addr | input | ADDR_W | Address of the opcode word |
| op_sp | input | ADDR_W | Current stack pointer |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| ext_valid | input | 1 | Extension word offered |
| ext_ready | output | 1 | Extension word will be taken |
| ext_word | input | 16 | Extension word |
| res_valid | output | 1 | Result presented |
| res_ready | input | 1 | Result consumed |
| res_taken | output | 1 | Branch taken |
| res_target | output | ADDR_W | Branch target address |
| res_next | output | ADDR_W | Fall-through address |
| res_push | output | 1 | Call variant: push request |
| res_push_data | output | ADDR_W | Value to push |
| res_sp_new | output | ADDR_W | Stack pointer after the push |

## Verification
The bench builds the unit with the default ADDR_W of 32. At this width the 32-bit displacement form covers the full address space, so target arithmetic that wraps past the top of memory and large negative displacements can be reached, and the stack step comes out as 4. All sixteen conditions are swept against all sixteen flag combinations. The bench also delays extension words, holds results back, and offers extension words while the unit is idle, so the handshake rules of R7 and R8 are exercised.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXT_HI = 2'd1,
        ST_EXT_LO = 2'd2,
        ST_DONE   = 2'd3
    } bru_state_e;

    typedef enum logic [1:0] {
        FORM_SHORT = 2'd0,
        FORM_WORD  = 2'd1,
        FORM_LONG  = 2'd2
    } bru_form_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } bru_flags_t;

    localparam logic [3:0] COND_ALWAYS = 4'b0000;
    localparam logic [3:0] COND_CALL   = 4'b0001;
    localparam logic [7:0] ESC_WORD    = 8'h00;
    localparam logic [7:0] ESC_LONG    = 8'hFF;
    localparam int         WORD_BYTES  = 2;

    function automatic bru_form_e form_of(input logic [7:0] d8);
        if (d8 == ESC_WORD)      return FORM_WORD;
        else if (d8 == ESC_LONG) return FORM_LONG;
        else                     return FORM_SHORT;
    endfunction

    // number of extension words that follow the opcode
    function automatic logic [1:0] ext_count(input bru_form_e f);
        case (f)
            FORM_WORD: return 2'd1;
            FORM_LONG: return 2'd2;
            default:   return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
(
    input  logic [3:0] cc,
    input  bru_flags_t fl,
    output logic       take,
    output logic       is_call
);
    logic sgn_ok;

    always_comb begin
        sgn_ok  = (fl.n == fl.v);
        is_call = (cc == COND_CALL);
        case (cc)
            4'b0000, 4'b0001: take = 1'b1;
            4'b0010: take = !fl.c && !fl.z;
            4'b0011: take = fl.c || fl.z;
            4'b0100: take = !fl.c;
            4'b0101: take = fl.c;
            4'b0110: take = !fl.z;
            4'b0111: take = fl.z;
            4'b1000: take = !fl.v;
            4'b1001: take = fl.v;
            4'b1010: take = !fl.n;
            4'b1011: take = fl.n;
            4'b1100: take = sgn_ok;
            4'b1101: take = !sgn_ok;
            4'b1110: take = sgn_ok && !fl.z;
            default: take = fl.z || !sgn_ok;
        endcase
    end
endmodule

// File: rtl/bru_seq.sv
module bru_seq
    import bru_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [15:0]       op_word,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] op_sp,
    input  bru_flags_t        flags_in,
    input  logic              ext_valid,
    output logic              ext_ready,
    input  logic [15:0]       ext_word,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [3:0]        cc_q,
    output bru_flags_t        flags_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] sp_q,
    output logic [31:0]       disp_q,
    output bru_form_e         form_q
);
    bru_state_e state;
    bru_form_e  form_in;
    logic       op_fire;
    logic       ext_fire;

    always_comb begin
        form_in   = form_of(op_word[7:0]);
        op_ready  = (state == ST_IDLE);
        ext_ready = (state == ST_EXT_HI) || (state == ST_EXT_LO);
        res_valid = (state == ST_DONE);
        op_fire   = op_valid && op_ready;
        ext_fire  = ext_valid && ext_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cc_q    <= '0;
            flags_q <= '0;
            addr_q  <= '0;
            sp_q    <= '0;
            disp_q  <= '0;
            form_q  <= FORM_SHORT;
        end else begin
            case (state)
                ST_IDLE: if (op_fire) begin
                    cc_q    <= op_word[11:8];
                    flags_q <= flags_in;
                    addr_q  <= op_addr;
                    sp_q    <= op_sp;
                    form_q  <= form_in;
                    disp_q  <= {{24{op_word[7]}}, op_word[7:0]};
                    state   <= (form_in == FORM_SHORT) ? ST_DONE : ST_EXT_HI;
                end
                ST_EXT_HI: if (ext_fire) begin
                    if (form_q == FORM_WORD) begin
                        disp_q <= {{16{ext_word[15]}}, ext_word};
                        state  <= ST_DONE;
                    end else begin
                        disp_q[31:16] <= ext_word;
                        state         <= ST_EXT_LO;
                    end
                end
                ST_EXT_LO: if (ext_fire) begin
                    disp_q[15:0] <= ext_word;
                    state        <= ST_DONE;
                end
                default: if (res_ready) state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bru_addr.sv
module bru_addr
    import bru_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [ADDR_W-1:0] sp_q,
    input  logic [31:0]       disp_q,
    input  bru_form_e         form_q,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] next,
    output logic [ADDR_W-1:0] sp_new
);
    localparam int PUSH_BYTES = ADDR_W / 8;

    logic [2:0] len_bytes;

    always_comb begin
        len_bytes = 3'(WORD_BYTES) * (3'(ext_count(form_q)) + 3'd1);
        target    = addr_q + ADDR_W'(WORD_BYTES) + ADDR_W'($signed(disp_q));
        next      = addr_q + ADDR_W'(len_bytes);
        sp_new    = sp_q - ADDR_W'(PUSH_BYTES);
    end
endmodule

// File: rtl/bru_top.sv
module bru_top
    import bru_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [15:0]       op_word,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] op_sp,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic              ext_valid,
    output logic              ext_ready,
    input  logic [15:0]       ext_word,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_taken,
    output logic [ADDR_W-1:0] res_target,
    output logic [ADDR_W-1:0] res_next,
    output logic              res_push,
    output logic [ADDR_W-1:0] res_push_data,
    output logic [ADDR_W-1:0] res_sp_new
);
    bru_flags_t        flags_in;
    bru_flags_t        flags_q;
    logic [3:0]        cc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] sp_q;
    logic [31:0]       disp_q;
    bru_form_e         form_q;
    logic [ADDR_W-1:0] next_w;

    assign flags_in = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    bru_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_ready(op_ready), .op_word(op_word),
        .op_addr(op_addr), .op_sp(op_sp), .flags_in(flags_in),
        .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_word(ext_word),
        .res_valid(res_valid), .res_ready(res_ready),
        .cc_q(cc_q), .flags_q(flags_q), .addr_q(addr_q), .sp_q(sp_q),
        .disp_q(disp_q), .form_q(form_q)
    );

    bru_cond u_cond (
        .cc(cc_q), .fl(flags_q), .take(res_taken), .is_call(res_push)
    );

    bru_addr #(.ADDR_W(ADDR_W)) u_addr (
        .addr_q(addr_q), .sp_q(sp_q), .disp_q(disp_q), .form_q(form_q),
        .target(res_target), .next(next_w), .sp_new(res_sp_new)
    );

    assign res_next      = next_w;
    assign res_push_data = next_w;
endmodule

// File: rtl/bru_chk.sv
module bru_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic              op_ready,
    input logic [15:0]       op_word,
    input logic              ext_ready,
    input logic              res_valid,
    input logic              res_ready,
    input logic              res_taken,
    input logic              res_push,
    input logic [ADDR_W-1:0] res_target
);
    logic op_fire;
    logic op_esc;

    assign op_fire = op_valid && op_ready;
    assign op_esc  = (op_word[7:0] == 8'h00) || (op_word[7:0] == 8'hFF);

    AST_SHORT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        op_fire && !op_esc |=> res_valid); // R1

    AST_ESC_WAITS_EXT: assert property (@(posedge clk) disable iff (rst)
        op_fire && op_esc |=> !res_valid && ext_ready); // R2

    AST_NO_EXT_IDLE: assert property (@(posedge clk) disable iff (rst)
        op_ready |-> !ext_ready); // R7

    AST_NO_EXT_PENDING: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !ext_ready); // R7

    AST_NO_OP_PENDING: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !op_ready); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |=> res_valid && $stable(res_target) && $stable(res_taken)); // R8

    AST_CALL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_push |-> res_taken); // R6
endmodule

bind bru_top bru_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_word(op_word), .ext_ready(ext_ready), .res_valid(res_valid),
    .res_ready(res_ready), .res_taken(res_taken), .res_push(res_push),
    .res_target(res_target)
);

// File: tb/sim_bru_top.sv
`timescale 1ns/1ps
module sim_bru_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic [15:0]   op_word = '0;
    logic [AW-1:0] op_addr = '0;
    logic [AW-1:0] op_sp = '0;
    logic          flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic          ext_valid = 1'b0;
    logic          ext_ready;
    logic [15:0]   ext_word = '0;
    logic          res_valid;
    logic          res_ready = 1'b0;
    logic          res_taken;
    logic [AW-1:0] res_target, res_next, res_push_data, res_sp_new;
    logic          res_push;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic          taken;
        logic [AW-1:0] target;
        logic [AW-1:0] next;
        logic          push;
        logic [AW-1:0] sp_new;
        int            hold;
        string         req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    bru_top #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_word(op_word), .op_addr(op_addr), .op_sp(op_sp),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_word(ext_word),
        .res_valid(res_valid), .res_ready(res_ready), .res_taken(res_taken),
        .res_target(res_target), .res_next(res_next), .res_push(res_push),
        .res_push_data(res_push_data), .res_sp_new(res_sp_new)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic model_take(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, v, c;
        {n, z, v, c} = f;
        case (cc)
            4'd0, 4'd1: return 1'b1;
            4'd2:  return ~(c | z);
            4'd3:  return c | z;
            4'd4:  return ~c;
            4'd5:  return c;
            4'd6:  return ~z;
            4'd7:  return z;
            4'd8:  return ~v;
            4'd9:  return v;
            4'd10: return ~n;
            4'd11: return n;
            4'd12: return ~(n ^ v);
            4'd13: return n ^ v;
            4'd14: return ~z & ~(n ^ v);
            default: return z | (n ^ v);
        endcase
    endfunction

    task automatic send_ext(input logic [15:0] w);
        @(negedge clk);
        ext_valid = 1'b1;
        ext_word  = w;
        while (!ext_ready) @(negedge clk);
        @(posedge clk);
        #1 ext_valid = 1'b0;
        ext_word = 16'hBAD0;
    endtask

    task automatic issue(input logic [15:0] op, input logic [AW-1:0] addr, input logic [AW-1:0] sp,
                         input logic [3:0] f, input logic [15:0] e_hi, input logic [15:0] e_lo,
                         input int hold, input bit gap, input string req);
        exp_t e;
        logic [31:0] disp;
        int nw;
        if (op[7:0] == 8'h00) begin
            nw = 1; disp = {{16{e_hi[15]}}, e_hi};
        end else if (op[7:0] == 8'hFF) begin
            nw = 2; disp = {e_hi, e_lo};
        end else begin
            nw = 0; disp = {{24{op[7]}}, op[7:0]};
        end
        e.taken  = model_take(op[11:8], f);
        e.target = addr + 32'd2 + disp;
        e.next   = addr + 32'(2 + 2 * nw);
        e.push   = (op[11:8] == 4'b0001);
        e.sp_new = sp - 32'd4;
        e.hold   = hold;
        e.req    = req;
        sb.push_back(e);
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        op_valid = 1'b1;
        op_word  = op;
        op_addr  = addr;
        op_sp    = sp;
        {flag_n, flag_z, flag_v, flag_c} = f;
        @(posedge clk);
        #1 op_valid = 1'b0;
        // R9: disturb sampled inputs after acceptance
        {flag_n, flag_z, flag_v, flag_c} = ~f;
        op_sp   = 32'hDEAD_0000;
        op_addr = 32'h5555_5555;
        if (gap) begin
            @(negedge clk);
            @(negedge clk);
        end
        if (nw >= 1) send_ext(e_hi);
        if (nw == 2) begin
            if (gap) @(negedge clk);
            send_ext(e_lo);
        end
    endtask

    // monitor: pops expected results as they appear
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (res_valid) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R8: unexpected result actual target %h expected none", res_target);
                end else begin
                    e = sb.pop_front();
                    chk({e.req, " taken"},  AW'(res_taken), AW'(e.taken));
                    chk({e.req, " target"}, res_target, e.target);
                    chk({e.req, " next"},   res_next, e.next);
                    chk({e.req, " R10 push"}, AW'(res_push), AW'(e.push));
                    if (e.push) begin
                        chk("R6 push data", res_push_data, e.next);
                        chk("R6 sp new", res_sp_new, e.sp_new);
                    end
                    for (int i = 0; i < e.hold; i++) begin
                        @(negedge clk);
                        chk("R8 hold valid", AW'({res_valid, op_ready}), AW'(2'b10));
                        chk("R7 no ext while pending", AW'(ext_ready), AW'(0));
                        chk("R8 hold target", res_target, e.target);
                    end
                    res_ready = 1'b1;
                    @(negedge clk);
                    res_ready = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset op_ready", AW'(op_ready), AW'(1));
        chk("R7 reset ext_ready", AW'(ext_ready), AW'(0));
        chk("R8 reset res_valid", AW'(res_valid), AW'(0));

        // R7: extension words offered while idle are ignored
        ext_valid = 1'b1;
        ext_word  = 16'h7FFF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 idle ext_ready", AW'(ext_ready), AW'(0));
            chk("R7 idle no result", AW'(res_valid), AW'(0));
        end
        ext_valid = 1'b0;
        issue(16'h6000, 32'h0000_1000, 32'h0000_8000, 4'h0, 16'h0004, 16'h0, 0, 0, "R7 R2");

        // R1 short forms
        issue(16'h6010, 32'h0000_2000, 32'h0, 4'h0, 16'h0, 16'h0, 0, 0, "R1 R5 pos");
        issue(16'h6080, 32'h0000_2000, 32'h0, 4'h0, 16'h0, 16'h0, 2, 0, "R1 neg");
        issue(16'h60FE, 32'hFFFF_FFFC, 32'h0, 4'h0, 16'h0, 16'h0, 0, 0, "R1 minus2");

        // R2 word forms
        issue(16'h6000, 32'h0000_3000, 32'h0, 4'h0, 16'h0000, 16'h0, 0, 1, "R2 zero");
        issue(16'h6000, 32'h0000_3000, 32'h0, 4'h0, 16'h8000, 16'h0, 1, 0, "R2 neg");

        // R3 long forms
        issue(16'h60FF, 32'h0000_4000, 32'h0, 4'h0, 16'h0001, 16'h2345, 0, 1, "R3 pos");
        issue(16'h60FF, 32'h0000_4000, 32'h0, 4'h0, 16'hFFFF, 16'hFFFE, 3, 0, "R3 neg");
        issue(16'h60FF, 32'hFFFF_FFF0, 32'h0, 4'h0, 16'h0000, 16'h0020, 0, 0, "R3 wrap");

        // R6 call in each form
        issue(16'h6124, 32'h0000_5000, 32'h0001_0000, 4'h4, 16'h0, 16'h0, 0, 0, "R6 short");
        issue(16'h6100, 32'h0000_5000, 32'h0001_0000, 4'h0, 16'hFF00, 16'h0, 0, 1, "R6 word");
        issue(16'h61FF, 32'h0000_5000, 32'h0000_0002, 4'hF, 16'h0010, 16'h0000, 1, 0, "R6 long");

        // R4 R9: sweep every condition against every flag set
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                issue({4'h6, 4'(cc), 8'h20}, 32'h0001_0000 + 32'(f * 16), 32'h0000_0100,
                      4'(f), 16'h0, 16'h0, (f == 5) ? 1 : 0, 0, "R4 R9 sweep");
            end
        end

        while (sb.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule